// File: doc/BRIEF.md
# ARINC 429 Style Parallel Host Adapter

This block sits between a 16-bit parallel processor bus and the word FIFOs of a two-receiver, one-transmitter serial avionics controller. All host controls are sampled on the system clock, and each active-low strobe acts once, on the clock edge where it is first seen low. A transmit word is built from two half-word loads. The low half is loaded first and the high half second. The finished 32-bit word goes into the transmit FIFO on the cycle after the second load. If the FIFO is full, the word is dropped and a sticky overflow bit is set.

Reads use a shared data path, split into a data output and a driver enable for a chip-level tri-state pad. The receiver 1 enable wins over the receiver 2 enable. A half-select line picks the 16-bit half of the head word. A receive FIFO advances only when an access that read its upper half ends. When neither receiver is enabled, a register read returns either the 8-bit control register or the 8-bit status register, chosen by a select line. The block also drives registered ready, half-full and full flags for each receive FIFO, half-full and full flags for the transmit FIFO, and a transmitter-ready flag.

Top module: `a429_host_port`

## Requirements
- R1: On a falling `ld_lo_n` the adapter keeps `host_wdata` as bits 15:0. On a later falling `ld_hi_n` it takes `host_wdata` as bits 31:16. In the clock cycle after that second strobe, `txq_push` is high for one cycle and `txq_word` carries the 32-bit word.
- R2: A falling `ld_hi_n` with no pending low half produces no push. A second falling `ld_lo_n` before the high half replaces the pending low half.
- R3: If `txq_full` is high in the push cycle, the word is dropped (no `txq_push`) and status bit 6 (overflow) is set. That bit stays set until the next control-register write, which clears it.
- R4: `tx_rdy` is 1 after reset. It goes to 0 on the clock edge that ends a push cycle, and it returns to 1 only on an edge where `txq_empty`=1 and `txq_busy`=0.
- R5: While `rx1_en_n`=0 the read path carries receiver 1 data. Receiver 2 data appears only when `rx2_en_n`=0 and `rx1_en_n`=1.
- R6: `half_sel`=0 selects head bits 15:0 and `half_sel`=1 selects bits 31:16 of the enabled receiver.
- R7: A receiver's `rxqN_pop` pulses for one cycle after its effective enable is released, but only if `half_sel` was 1 at some point during that access and that FIFO is not empty at release. An access that reads only the lower half does not pop.
- R8: On a falling `ctl_wr_n` the control register takes `host_wdata[7:0]`. When neither receiver enable is active and `reg_rd_n`=0, the read path returns the control register if `reg_sel`=1 and the status register if `reg_sel`=0, with bits 15:8 reading 0.
- R9: Status bit layout: 0 receiver 1 ready, 1 receiver 1 half full, 2 receiver 2 ready, 3 receiver 2 half full, 4 transmit half full, 5 transmit full, 6 overflow, 7 transmitter ready. After reset with all FIFOs empty it reads 0x80.
- R10: Host flags follow the FIFO side one clock later. `rxN_rdy` = not `rxqN_empty`, `rxN_hf` = `rxqN_half`, `rxN_ff` = `rxqN_full`, `txf_hf` = `txq_half`, `txf_ff` = `txq_full`.
- R11: `host_rdata_oe` is 1 only while a receiver enable or `reg_rd_n` is active. Otherwise `host_rdata` is 0.
- R12: One clock after it is sampled, `xmit_allow` equals `xmit_go` and `line_drive` equals the inverse of `xmit_inhibit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_rdata_oe | output | 1 | Drive enable for the read pad |
| ld_lo_n | input | 1 | Load strobe, low half |
| ld_hi_n | input | 1 | Load strobe, high half |
| rx1_en_n | input | 1 | Receiver 1 read enable (priority) |
| rx2_en_n | input | 1 | Receiver 2 read enable |
| half_sel | input | 1 | 0 lower half, 1 upper half |
| ctl_wr_n | input | 1 | Control register write strobe |
| reg_rd_n | input | 1 | Register read enable |
| reg_sel | input | 1 | 0 status, 1 control |
| xmit_go | input | 1 | Permit transmission to start |
| xmit_inhibit | input | 1 | Disable line output when high |
| rx1_rdy | output | 1 | Receiver 1 FIFO not empty |
| rx1_hf | output | 1 | Receiver 1 FIFO half full |
| rx1_ff | output | 1 | Receiver 1 FIFO full |
| rx2_rdy | output | 1 | Receiver 2 FIFO not empty |
| rx2_hf | output | 1 | Receiver 2 FIFO half full |
| rx2_ff | output | 1 | Receiver 2 FIFO full |
| txf_hf | output | 1 | Transmit FIFO half full |
| txf_ff | output | 1 | Transmit FIFO full |
| tx_rdy | output | 1 | Transmitter ready |
| xmit_allow | output | 1 | Registered transmit permission |
| line_drive | output | 1 | Registered line output enable |
| txq_push | output | 1 | Transmit FIFO write |
| txq_word | output | 32 | Transmit FIFO write word |
| txq_full | input | 1 | Transmit FIFO full |
| txq_half | input | 1 | Transmit FIFO half full |
| txq_empty | input | 1 | Transmit FIFO empty |
| txq_busy | input | 1 | Serialiser sending |
| rxq1_head | input | 32 | Receiver 1 FIFO head word |
| rxq1_empty | input | 1 | Receiver 1 FIFO empty |
| rxq1_half | input | 1 | Receiver 1 FIFO half full |
| rxq1_full | input | 1 | Receiver 1 FIFO full |
| rxq1_pop | output | 1 | Receiver 1 FIFO read |
| rxq2_head | input | 32 | Receiver 2 FIFO head word |
| rxq2_empty | input | 1 | Receiver 2 FIFO empty |
| rxq2_half | input | 1 | Receiver 2 FIFO half full |
| rxq2_full | input | 1 | Receiver 2 FIFO full |
| rxq2_pop | output | 1 | Receiver 2 FIFO read |

## Verification
The assertions assume three things about the environment. Every strobe and enable is driven synchronously and held for at least one full clock. A FIFO's head word does not change during an access to it. The control-register strobe is never active in the same cycle as an overflow, because set wins over clear in that case. The bench drives all inputs on the falling clock edge, holds each strobe low for exactly one cycle, and changes head words and FIFO flags only while no enable is active. Its stimulus includes the orphan, overwrite and full-FIFO cases.

// File: rtl/a429_host_pkg.sv
`timescale 1ns/1ps
package a429_host_pkg;
    localparam int NUM_RX = 2;
    localparam int STAT_W = 8;

    // status bit positions
    localparam int ST_RX1_RDY = 0;
    localparam int ST_RX1_HF  = 1;
    localparam int ST_RX2_RDY = 2;
    localparam int ST_RX2_HF  = 3;
    localparam int ST_TX_HF   = 4;
    localparam int ST_TX_FF   = 5;
    localparam int ST_OVF     = 6;
    localparam int ST_TX_RDY  = 7;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_RX1  = 2'd1,
        SRC_RX2  = 2'd2,
        SRC_REG  = 2'd3
    } rd_src_e;
endpackage

// File: rtl/a429_tx_loader.sv
`timescale 1ns/1ps
module a429_tx_loader #(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_lo_n,
    input  logic                  ld_hi_n,
    input  logic [HALF_W-1:0]     wdata,
    input  logic                  fifo_full,
    input  logic                  fifo_empty,
    input  logic                  ser_busy,
    input  logic                  ovf_clr,
    output logic                  push,
    output logic [2*HALF_W-1:0]   word,
    output logic                  ready,
    output logic                  ovf
);
    localparam int WORD_W = 2 * HALF_W;

    typedef struct packed {
        logic              prev_lo;
        logic              prev_hi;
        logic              have_lo;
        logic [HALF_W-1:0] lo;
        logic [WORD_W-1:0] word;
        logic              pend;
        logic              ovf;
        logic              rdy;
    } st_t;

    localparam st_t ST_RST = '{prev_lo: 1'b1, prev_hi: 1'b1, have_lo: 1'b0,
                               lo: '0, word: '0, pend: 1'b0, ovf: 1'b0,
                               rdy: 1'b1};

    st_t  st_d, st_q;
    logic lo_stb, hi_stb;

    always_comb begin
        st_d         = st_q;
        st_d.prev_lo = ld_lo_n;
        st_d.prev_hi = ld_hi_n;
        lo_stb       = st_q.prev_lo & ~ld_lo_n;
        hi_stb       = st_q.prev_hi & ~ld_hi_n;
        push         = st_q.pend & ~fifo_full;
        st_d.pend    = 1'b0;

        if (st_q.pend && fifo_full) begin
            st_d.ovf = 1'b1;
        end else if (ovf_clr) begin
            st_d.ovf = 1'b0;
        end

        if (hi_stb && st_q.have_lo) begin
            st_d.word    = {wdata, st_q.lo};
            st_d.pend    = 1'b1;
            st_d.have_lo = 1'b0;
        end
        if (lo_stb) begin
            st_d.lo      = wdata;
            st_d.have_lo = 1'b1;
        end

        if (push) begin
            st_d.rdy = 1'b0;
        end else if (fifo_empty && !ser_busy) begin
            st_d.rdy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign word  = st_q.word;
    assign ready = st_q.rdy;
    assign ovf   = st_q.ovf;

    AST_PUSH_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push); // R1
    AST_ORPHAN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_stb && !st_q.have_lo) |=> !st_q.pend); // R2
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !ovf_clr) |=> st_q.ovf); // R3
    AST_PUSH_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !ready); // R4
endmodule

// File: rtl/a429_rx_reader.sv
`timescale 1ns/1ps
module a429_rx_reader #(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel,
    input  logic                  half_sel,
    input  logic [2*HALF_W-1:0]   head,
    input  logic                  fifo_empty,
    input  logic                  fifo_half,
    input  logic                  fifo_full,
    output logic [HALF_W-1:0]     rd_half,
    output logic                  rdy,
    output logic                  hf,
    output logic                  ff,
    output logic                  pop
);
    typedef struct packed {
        logic act;
        logic upper;
        logic rdy;
        logic hf;
        logic ff;
        logic pop;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rdy = ~fifo_empty;
        st_d.hf  = fifo_half;
        st_d.ff  = fifo_full;
        st_d.pop = 1'b0;
        if (sel && !st_q.act) begin
            st_d.act   = 1'b1;
            st_d.upper = half_sel;
        end else if (sel) begin
            st_d.upper = st_q.upper | half_sel;
        end else if (st_q.act) begin
            st_d.act   = 1'b0;
            st_d.upper = 1'b0;
            st_d.pop   = st_q.upper & ~fifo_empty;
        end
        rd_half = half_sel ? head[2*HALF_W-1:HALF_W] : head[HALF_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdy = st_q.rdy;
    assign hf  = st_q.hf;
    assign ff  = st_q.ff;
    assign pop = st_q.pop;

    AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !pop); // R7
    AST_POP_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.act && !sel) |=> !pop); // R7
endmodule

// File: rtl/a429_host_port.sv
`timescale 1ns/1ps
module a429_host_port
    import a429_host_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int CTRL_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HALF_W-1:0]    host_wdata,
    output logic [HALF_W-1:0]    host_rdata,
    output logic                 host_rdata_oe,
    input  logic                 ld_lo_n,
    input  logic                 ld_hi_n,
    input  logic                 rx1_en_n,
    input  logic                 rx2_en_n,
    input  logic                 half_sel,
    input  logic                 ctl_wr_n,
    input  logic                 reg_rd_n,
    input  logic                 reg_sel,
    input  logic                 xmit_go,
    input  logic                 xmit_inhibit,
    output logic                 rx1_rdy,
    output logic                 rx1_hf,
    output logic                 rx1_ff,
    output logic                 rx2_rdy,
    output logic                 rx2_hf,
    output logic                 rx2_ff,
    output logic                 txf_hf,
    output logic                 txf_ff,
    output logic                 tx_rdy,
    output logic                 xmit_allow,
    output logic                 line_drive,
    output logic                 txq_push,
    output logic [2*HALF_W-1:0]  txq_word,
    input  logic                 txq_full,
    input  logic                 txq_half,
    input  logic                 txq_empty,
    input  logic                 txq_busy,
    input  logic [2*HALF_W-1:0]  rxq1_head,
    input  logic                 rxq1_empty,
    input  logic                 rxq1_half,
    input  logic                 rxq1_full,
    output logic                 rxq1_pop,
    input  logic [2*HALF_W-1:0]  rxq2_head,
    input  logic                 rxq2_empty,
    input  logic                 rxq2_half,
    input  logic                 rxq2_full,
    output logic                 rxq2_pop
);
    localparam int WORD_W = 2 * HALF_W;

    typedef struct packed {
        logic              prev_ctl;
        logic [CTRL_W-1:0] ctrl;
        logic              txhf;
        logic              txff;
        logic              allow;
        logic              drive;
    } st_t;

    localparam st_t ST_RST = '{prev_ctl: 1'b1, ctrl: '0, txhf: 1'b0,
                               txff: 1'b0, allow: 1'b0, drive: 1'b0};

    st_t              st_d, st_q;
    logic             ctl_stb;
    logic             ovf;
    rd_src_e          src;
    logic [STAT_W-1:0] status;
    logic [HALF_W-1:0] reg_word;

    logic [NUM_RX-1:0] sel_v, empty_v, half_v, full_v, rdy_v, hf_v, ff_v, pop_v;
    logic [WORD_W-1:0] head_v [NUM_RX];
    logic [HALF_W-1:0] rd_v   [NUM_RX];

    assign sel_v   = {~rx2_en_n & rx1_en_n, ~rx1_en_n};
    assign empty_v = {rxq2_empty, rxq1_empty};
    assign half_v  = {rxq2_half, rxq1_half};
    assign full_v  = {rxq2_full, rxq1_full};
    assign head_v[0] = rxq1_head;
    assign head_v[1] = rxq2_head;

    generate
        for (genvar g = 0; g < NUM_RX; g++) begin : g_rx
            a429_rx_reader #(.HALF_W(HALF_W)) u_reader (
                .clk        (clk),
                .rst_n      (rst_n),
                .sel        (sel_v[g]),
                .half_sel   (half_sel),
                .head       (head_v[g]),
                .fifo_empty (empty_v[g]),
                .fifo_half  (half_v[g]),
                .fifo_full  (full_v[g]),
                .rd_half    (rd_v[g]),
                .rdy        (rdy_v[g]),
                .hf         (hf_v[g]),
                .ff         (ff_v[g]),
                .pop        (pop_v[g])
            );
        end
    endgenerate

    a429_tx_loader #(.HALF_W(HALF_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_lo_n    (ld_lo_n),
        .ld_hi_n    (ld_hi_n),
        .wdata      (host_wdata),
        .fifo_full  (txq_full),
        .fifo_empty (txq_empty),
        .ser_busy   (txq_busy),
        .ovf_clr    (ctl_stb),
        .push       (txq_push),
        .word       (txq_word),
        .ready      (tx_rdy),
        .ovf        (ovf)
    );

    always_comb begin
        st_d          = st_q;
        st_d.prev_ctl = ctl_wr_n;
        ctl_stb       = st_q.prev_ctl & ~ctl_wr_n;
        if (ctl_stb) st_d.ctrl = host_wdata[CTRL_W-1:0];
        st_d.txhf  = txq_half;
        st_d.txff  = txq_full;
        st_d.allow = xmit_go;
        st_d.drive = ~xmit_inhibit;

        status             = '0;
        status[ST_RX1_RDY] = rdy_v[0];
        status[ST_RX1_HF]  = hf_v[0];
        status[ST_RX2_RDY] = rdy_v[1];
        status[ST_RX2_HF]  = hf_v[1];
        status[ST_TX_HF]   = st_q.txhf;
        status[ST_TX_FF]   = st_q.txff;
        status[ST_OVF]     = ovf;
        status[ST_TX_RDY]  = tx_rdy;

        reg_word = '0;
        if (reg_sel) reg_word[CTRL_W-1:0] = st_q.ctrl;
        else         reg_word[STAT_W-1:0] = status;

        if (!rx1_en_n)      src = SRC_RX1;
        else if (!rx2_en_n) src = SRC_RX2;
        else if (!reg_rd_n) src = SRC_REG;
        else                src = SRC_NONE;

        case (src)
            SRC_RX1: host_rdata = rd_v[0];
            SRC_RX2: host_rdata = rd_v[1];
            SRC_REG: host_rdata = reg_word;
            default: host_rdata = '0;
        endcase
        host_rdata_oe = (src != SRC_NONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign rx1_rdy    = rdy_v[0];
    assign rx1_hf     = hf_v[0];
    assign rx1_ff     = ff_v[0];
    assign rx2_rdy    = rdy_v[1];
    assign rx2_hf     = hf_v[1];
    assign rx2_ff     = ff_v[1];
    assign rxq1_pop   = pop_v[0];
    assign rxq2_pop   = pop_v[1];
    assign txf_hf     = st_q.txhf;
    assign txf_ff     = st_q.txff;
    assign xmit_allow = st_q.allow;
    assign line_drive = st_q.drive;

    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx1_en_n && rx2_en_n && reg_rd_n) |-> (!host_rdata_oe && host_rdata == '0)); // R11
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_stb |=> $stable(st_q.ctrl)); // R8
    AST_RX2_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx1_en_n && !rx2_en_n) |-> !sel_v[1]); // R5
    AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_stb && !txq_push && !txq_full) |=> !ovf); // R3
endmodule

// File: tb/a429_host_port_bench.sv
`timescale 1ns/1ps
module a429_host_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rdata_oe;
    logic        ld_lo_n = 1'b1, ld_hi_n = 1'b1;
    logic        rx1_en_n = 1'b1, rx2_en_n = 1'b1, half_sel = 1'b0;
    logic        ctl_wr_n = 1'b1, reg_rd_n = 1'b1, reg_sel = 1'b0;
    logic        xmit_go = 1'b0, xmit_inhibit = 1'b1;
    logic        rx1_rdy, rx1_hf, rx1_ff, rx2_rdy, rx2_hf, rx2_ff;
    logic        txf_hf, txf_ff, tx_rdy, xmit_allow, line_drive;
    logic        txq_push;
    logic [31:0] txq_word;
    logic        txq_full = 1'b0, txq_half = 1'b0, txq_empty = 1'b1, txq_busy = 1'b0;
    logic [31:0] rxq1_head = '0, rxq2_head = '0;
    logic        rxq1_empty = 1'b1, rxq1_half = 1'b0, rxq1_full = 1'b0, rxq1_pop;
    logic        rxq2_empty = 1'b1, rxq2_half = 1'b0, rxq2_full = 1'b0, rxq2_pop;

    int n_chk = 0, n_bad = 0;
    int push_cnt = 0, pop1 = 0, pop2 = 0;
    logic [31:0] last_word = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    a429_host_port u_a429_host_port (.*);

    always @(posedge clk) begin
        if (rst_n) begin
            if (txq_push) begin push_cnt++; last_word = txq_word; end
            if (rxq1_pop) pop1++;
            if (rxq2_pop) pop2++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load(input logic [15:0] v, input bit hi);
        @(negedge clk);
        host_wdata = v;
        if (hi) ld_hi_n = 1'b0; else ld_lo_n = 1'b0;
        @(negedge clk);
        ld_hi_n = 1'b1; ld_lo_n = 1'b1;
    endtask

    task automatic read_reg(input bit sel, output logic [15:0] v, output logic oe);
        @(negedge clk);
        reg_sel = sel; reg_rd_n = 1'b0;
        #1; v = host_rdata; oe = host_rdata_oe;
        @(negedge clk);
        reg_rd_n = 1'b1;
    endtask

    task automatic ctl_write(input logic [15:0] v);
        @(negedge clk);
        host_wdata = v; ctl_wr_n = 1'b0;
        @(negedge clk);
        ctl_wr_n = 1'b1;
    endtask

    task automatic rx_read(input bit e1, input bit e2, input bit hs, output logic [15:0] v);
        @(negedge clk);
        half_sel = hs; rx1_en_n = ~e1; rx2_en_n = ~e2;
        #1; v = host_rdata;
        @(negedge clk);
        rx1_en_n = 1'b1; rx2_en_n = 1'b1; half_sel = 1'b0;
        cyc(3);
    endtask

    task automatic t_reset;
        logic [15:0] v; logic oe;
        chk("R4 reset tx_rdy", tx_rdy, 1);
        chk("R11 idle oe", host_rdata_oe, 0);
        chk("R11 idle data", host_rdata, 0);
        read_reg(0, v, oe);
        chk("R9 reset status", v, 16'h0080);
        chk("R11 reg read oe", oe, 1);
    endtask

    task automatic t_tx_word;
        int p0 = push_cnt;
        load(16'h1234, 0);
        load(16'hABCD, 1);
        cyc(2);
        chk("R1 push count", push_cnt, p0 + 1);
        chk("R1 word", last_word, 32'hABCD_1234);
    endtask

    task automatic t_orphan_overwrite;
        int p0 = push_cnt;
        load(16'h7777, 1);
        cyc(2);
        chk("R2 orphan high half", push_cnt, p0);
        load(16'h1111, 0);
        load(16'h2222, 0);
        load(16'h3333, 1);
        cyc(2);
        chk("R2 overwrite count", push_cnt, p0 + 1);
        chk("R2 overwrite word", last_word, 32'h3333_2222);
    endtask

    task automatic t_overflow;
        int p0 = push_cnt;
        logic [15:0] v; logic oe;
        txq_full = 1'b1;
        load(16'h0001, 0);
        load(16'h0002, 1);
        cyc(2);
        chk("R3 dropped", push_cnt, p0);
        txq_full = 1'b0;
        cyc(2);
        read_reg(0, v, oe);
        chk("R3 overflow bit", v[6], 1);
        cyc(3);
        read_reg(0, v, oe);
        chk("R3 overflow sticky", v[6], 1);
        ctl_write(16'h005A);
        cyc(1);
        read_reg(0, v, oe);
        chk("R3 overflow cleared", v[6], 0);
    endtask

    task automatic t_tx_ready;
        txq_empty = 1'b0; txq_busy = 1'b1;
        cyc(1);
        chk("R4 ready before load", tx_rdy, 1);
        load(16'hBEEF, 0);
        load(16'hF00D, 1);
        cyc(2);
        chk("R4 ready low after push", tx_rdy, 0);
        txq_empty = 1'b1;
        cyc(2);
        chk("R4 ready held while busy", tx_rdy, 0);
        txq_busy = 1'b0;
        cyc(2);
        chk("R4 ready restored", tx_rdy, 1);
    endtask

    task automatic t_rx_halves;
        logic [15:0] v;
        int a = pop1;
        rxq1_head = 32'hCAFE_0001; rxq1_empty = 1'b0;
        cyc(1);
        rx_read(1, 0, 0, v);
        chk("R6 lower half", v, 16'h0001);
        chk("R7 no pop on lower read", pop1, a);
        rx_read(1, 0, 1, v);
        chk("R6 upper half", v, 16'hCAFE);
        chk("R7 pop on upper read", pop1, a + 1);
        rxq1_empty = 1'b1;
        cyc(1);
        rx_read(1, 0, 1, v);
        chk("R7 no pop when empty", pop1, a + 1);
    endtask

    task automatic t_priority;
        logic [15:0] v;
        int a = pop1, b = pop2;
        rxq1_head = 32'h1357_2468; rxq1_empty = 1'b0;
        rxq2_head = 32'h5555_AAAA; rxq2_empty = 1'b0;
        cyc(1);
        rx_read(1, 1, 1, v);
        chk("R5 receiver 1 wins", v, 16'h1357);
        chk("R5 rx1 popped", pop1, a + 1);
        chk("R5 rx2 not popped", pop2, b);
        rx_read(0, 1, 0, v);
        chk("R5 rx2 lower", v, 16'hAAAA);
        rx_read(0, 1, 1, v);
        chk("R5 rx2 upper", v, 16'h5555);
        chk("R7 rx2 popped", pop2, b + 1);
        rxq1_empty = 1'b1; rxq2_empty = 1'b1;
        cyc(2);
    endtask

    task automatic t_regs;
        logic [15:0] v; logic oe;
        ctl_write(16'hFFC3);
        read_reg(1, v, oe);
        chk("R8 control readback", v, 16'h00C3);
        read_reg(0, v, oe);
        chk("R8 status select", v, 16'h0080);
        @(negedge clk);
        rx1_en_n = 1'b0; reg_rd_n = 1'b0; reg_sel = 1'b1;
        rxq1_head = 32'h0000_4242;
        #1; chk("R8 receiver over register", host_rdata, 16'h4242);
        @(negedge clk);
        rx1_en_n = 1'b1; reg_rd_n = 1'b1;
        #1; chk("R11 released oe", host_rdata_oe, 0);
    endtask

    task automatic t_flags;
        logic [15:0] v; logic oe;
        rxq1_empty = 1'b0; rxq1_full = 1'b1;
        rxq2_half = 1'b1; txq_half = 1'b1; txq_full = 1'b1;
        @(negedge clk);
        chk("R10 rx1 ready", rx1_rdy, 1);
        chk("R10 rx1 full", rx1_ff, 1);
        chk("R10 rx2 half", rx2_hf, 1);
        chk("R10 tx half/full", {txf_hf, txf_ff}, 2'b11);
        read_reg(0, v, oe);
        chk("R9 status flags", v, 16'h00B9);
        rxq1_empty = 1'b1; rxq1_full = 1'b0;
        rxq2_half = 1'b0; txq_half = 1'b0; txq_full = 1'b0;
        cyc(2);
        chk("R10 flags cleared", {rx1_rdy, rx1_ff, rx2_hf, txf_hf, txf_ff}, 0);
    endtask

    task automatic t_xmit;
        chk("R12 reset allow", xmit_allow, 0);
        @(negedge clk);
        xmit_go = 1'b1; xmit_inhibit = 1'b0;
        @(negedge clk);
        chk("R12 allow", xmit_allow, 1);
        chk("R12 drive", line_drive, 1);
        xmit_inhibit = 1'b1;
        @(negedge clk);
        chk("R12 inhibit", line_drive, 0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(3);
        t_reset();
        t_tx_word();
        t_orphan_overwrite();
        t_overflow();
        t_tx_ready();
        t_rx_halves();
        t_priority();
        t_regs();
        t_flags();
        t_xmit();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule